// File: doc/BRIEF.md
# Flash Interrupt and Status Register Block

This block holds the two words a flash controller reports to its host: an interrupt word and a controller status word. It also drives the interrupt pin and a ready line. A command engine tells the block when an operation has finished. It does so through one pulse per kind of operation: load, program, erase, reset, and a generic done. Each pulse may carry error flags, and the block records them in the status word.

The host reaches the block through a single write port. It can write three targets: the interrupt word, the first configuration word, and the command register. A write to the interrupt word is ANDed into the current value, so a zero clears a bit and a one keeps it. When such a write leaves the master bit clear, the recorded errors are dropped in the same cycle. The block also gates commands. A command written while an interrupt is still pending is dropped. A command with an unrecognised code is never passed on; it raises a command error instead. The interrupt pin polarity is selected by one configuration bit.

Top module: `flash_irq_status`

## Requirements
- R1: On the asynchronous cold reset (`rst_ni` low) the interrupt word is 0x8080, the status word is 0x0000, the configuration word is 0x40C0 and `ready_o` is 1.
- R2: A cycle with `warm_rst_i` high loads the interrupt word with 0x8010, the status word with 0, the configuration word with 0x40C0 and sets `ready_o` to 1. This takes priority over every other input in that cycle.
- R3: A completion pulse sets bit 15 of the interrupt word and its own cause bit in the next cycle. The cause bits are load at bit 7, program at bit 6, erase at bit 5 and reset at bit 4. The done pulse sets bit 15 only. Without a pulse or a rejected command, no interrupt bit goes from 0 to 1.
- R4: Error flags that arrive with any completion pulse are ORed into the status word: command error at bit 10, erase at bit 11, program at bit 12, load at bit 13. Flags that arrive with no pulse are ignored. Error bits stay set until they are cleared.
- R5: A write with `wr_sel_i`=0 replaces the interrupt word with the bitwise AND of the current word and `wr_data_i`.
- R6: When an interrupt-word write leaves bit 15 clear, bits 13..10 of the status word are cleared in that same cycle. When bit 15 remains set, those bits are kept.
- R7: When a completion pulse and an interrupt-word write occur in the same cycle, the pulse's bits and error flags survive the AND, and no error bit is cleared.
- R8: `irq_o` equals bit 15 of the interrupt word XOR the inverse of bit 6 of the configuration word.
- R9: A write with `wr_sel_i`=1 loads the configuration word from `wr_data_i`, and from the next cycle `ready_o` equals `wr_data_i` bit 7.
- R10: A write with `wr_sel_i`=2 made while bit 15 of the interrupt word is set is ignored. No `cmd_valid_o` is produced and no word changes.
- R11: An accepted command with a known code drives `cmd_valid_o` high and `cmd_code_o` equal to `wr_data_i` in the same cycle. The known codes are 0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0071, 0x0094, 0x0095, 0x00B0, 0x0030, 0x00F0, 0x00F3 and 0x0065.
- R12: An accepted command with any other code does not raise `cmd_valid_o`. In the next cycle it sets bit 15 of the interrupt word and bit 10 of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Write target: 0 interrupt, 1 configuration, 2 command, 3 none |
| wr_data_i | input | 16 | Host write data |
| evt_load_i | input | 1 | Load completion pulse |
| evt_prog_i | input | 1 | Program completion pulse |
| evt_erase_i | input | 1 | Erase completion pulse |
| evt_reset_i | input | 1 | Reset completion pulse |
| evt_done_i | input | 1 | Generic completion pulse |
| err_cmd_i | input | 1 | Command error flag with a pulse |
| err_erase_i | input | 1 | Erase error flag with a pulse |
| err_prog_i | input | 1 | Program error flag with a pulse |
| err_load_i | input | 1 | Load error flag with a pulse |
| int_word_o | output | 16 | Interrupt word |
| status_word_o | output | 16 | Controller status word |
| cfg_word_o | output | 16 | Configuration word |
| irq_o | output | 1 | Interrupt pin |
| ready_o | output | 1 | Ready line |
| cmd_valid_o | output | 1 | Accepted known command, same cycle |
| cmd_code_o | output | 16 | Command code passed on |

## Verification
Some behaviours are checked by assertions on every clock:
- No interrupt bit rises without a pulse or a rejected command.
- A pulse always leaves the master bit set.
- An AND write never leaves a bit set that the write cleared.
- Error bits only fall when a clear or a warm reset occurs.
- No command passes while the master bit is set.
- `ready_o` tracks the configuration write.

Other behaviours only the bench scenarios can show:
- The exact reset values.
- The priority of a pulse over a same-cycle clear.
- The polarity flip of the pin.
- The split between known and unknown command codes.

The bench compares these against its own model on every cycle.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int WORD_W = 16;
  localparam int ERR_N  = 4;

  localparam int BIT_MST = 15;
  localparam int BIT_RST = 4;
  localparam int BIT_ERA = 5;
  localparam int BIT_PRG = 6;
  localparam int BIT_LD  = 7;

  localparam int ERR_LSB = 10;  // cmd, erase, prog, load upward

  localparam int CFG_POL = 6;
  localparam int CFG_RDY = 7;

  localparam logic [WORD_W-1:0] INT_COLD = 16'h8080;
  localparam logic [WORD_W-1:0] INT_WARM = 16'h8010;
  localparam logic [WORD_W-1:0] CFG_INIT = 16'h40C0;

  typedef enum logic [1:0] {
    SEL_INT  = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic ld;
    logic prg;
    logic era;
    logic rst;
    logic done;
  } evt_t;

  typedef struct packed {
    logic ld;
    logic prg;
    logic era;
    logic cmd;
  } err_t;

  function automatic logic cmd_known(input logic [WORD_W-1:0] c);
    case (c)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h00F0,
      16'h00F3, 16'h0065: return 1'b1;
      default:            return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fis_cmd_gate.sv
module fis_cmd_gate
  import fis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              master_i,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_code_o,
  output logic              cmd_bad_o
);
  logic accept;

  assign accept      = wr_cmd_i & ~master_i;
  assign cmd_valid_o = accept & cmd_known(data_i);
  assign cmd_bad_o   = accept & ~cmd_known(data_i);
  assign cmd_code_o  = data_i;

  p_blocked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> !(cmd_valid_o || cmd_bad_o));
  p_exclusive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && cmd_bad_o));
endmodule

// File: rtl/fis_int_word.sv
module fis_int_word
  import fis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] data_i,
  input  evt_t              evt_i,
  input  logic              bad_cmd_i,
  output logic [WORD_W-1:0] int_o,
  output logic              err_clr_o
);
  logic [WORD_W-1:0] int_q, base, set_mask, int_d;
  logic              any_evt;

  assign any_evt = (|evt_i) | bad_cmd_i;

  always_comb begin
    set_mask          = '0;
    set_mask[BIT_MST] = any_evt;
    set_mask[BIT_LD]  = evt_i.ld;
    set_mask[BIT_PRG] = evt_i.prg;
    set_mask[BIT_ERA] = evt_i.era;
    set_mask[BIT_RST] = evt_i.rst;
    base              = wr_i ? (int_q & data_i) : int_q;
    int_d             = base | set_mask;  // events win over a same-cycle clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     int_q <= INT_COLD;
    else if (warm_i) int_q <= INT_WARM;
    else             int_q <= int_d;
  end

  assign int_o     = int_q;
  assign err_clr_o = wr_i & ~int_d[BIT_MST];

  p_no_spurious_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!warm_i && !any_evt) |=> ((int_q & ~$past(int_q)) == '0));
  p_evt_sets_master_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!warm_i && (|evt_i)) |=> int_q[BIT_MST]);
  p_and_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !warm_i && !any_evt) |=> ((int_q & ~$past(data_i)) == '0));
  p_warm_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_i |=> (int_q == INT_WARM));
endmodule

// File: rtl/fis_status_word.sv
module fis_status_word
  import fis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_i,
  input  err_t              err_set_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] status_o
);
  logic [ERR_N-1:0] err_q, err_d;

  always_comb begin
    err_d = clr_i ? '0 : err_q;
    err_d = err_d | err_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= '0;
    else if (warm_i) err_q <= '0;
    else             err_q <= err_d;
  end

  always_comb begin
    status_o = '0;
    status_o[ERR_LSB +: ERR_N] = err_q;
  end

  p_err_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (err_set_i == '0) && !warm_i) |=> (status_o[ERR_LSB +: ERR_N] == '0));
  p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !warm_i) |=> (($past(err_q) & ~err_q) == '0));
endmodule

// File: rtl/fis_cfg.sv
module fis_cfg
  import fis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              master_i,
  output logic [WORD_W-1:0] cfg_o,
  output logic              rdy_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] cfg_q;
  logic              rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_INIT;
      rdy_q <= 1'b1;
    end else if (warm_i) begin
      cfg_q <= CFG_INIT;
      rdy_q <= 1'b1;
    end else if (wr_i) begin
      cfg_q <= data_i;
      rdy_q <= data_i[CFG_RDY];
    end
  end

  assign cfg_o = cfg_q;
  assign rdy_o = rdy_q;
  assign irq_o = master_i ^ ~cfg_q[CFG_POL];

  p_rdy_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !warm_i) |=> (rdy_o == $past(data_i[CFG_RDY])));
  p_rdy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !warm_i) |=> $stable(rdy_o));
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import fis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              evt_load_i,
  input  logic              evt_prog_i,
  input  logic              evt_erase_i,
  input  logic              evt_reset_i,
  input  logic              evt_done_i,
  input  logic              err_cmd_i,
  input  logic              err_erase_i,
  input  logic              err_prog_i,
  input  logic              err_load_i,
  output logic [WORD_W-1:0] int_word_o,
  output logic [WORD_W-1:0] status_word_o,
  output logic [WORD_W-1:0] cfg_word_o,
  output logic              irq_o,
  output logic              ready_o,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_code_o
);
  wr_sel_e sel;
  evt_t    evt;
  err_t    err_in, err_set;
  logic    wr_int, wr_cfg, wr_cmd, cmd_bad, err_clr, any_evt;
  logic [WORD_W-1:0] int_w;

  assign sel    = wr_sel_e'(wr_sel_i);
  assign wr_int = wr_en_i && (sel == SEL_INT);
  assign wr_cfg = wr_en_i && (sel == SEL_CFG);
  assign wr_cmd = wr_en_i && (sel == SEL_CMD);

  assign evt     = '{ld: evt_load_i, prg: evt_prog_i, era: evt_erase_i,
                     rst: evt_reset_i, done: evt_done_i};
  assign err_in  = '{ld: err_load_i, prg: err_prog_i, era: err_erase_i,
                     cmd: err_cmd_i};
  assign any_evt = |evt;

  // flags only count when they ride on a completion pulse
  always_comb begin
    err_set     = any_evt ? err_in : '0;
    err_set.cmd = err_set.cmd | cmd_bad;
  end

  fis_cmd_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_cmd_i    (wr_cmd),
    .data_i      (wr_data_i),
    .master_i    (int_w[BIT_MST]),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (cmd_code_o),
    .cmd_bad_o   (cmd_bad)
  );

  fis_int_word u_int (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .warm_i    (warm_rst_i),
    .wr_i      (wr_int),
    .data_i    (wr_data_i),
    .evt_i     (evt),
    .bad_cmd_i (cmd_bad),
    .int_o     (int_w),
    .err_clr_o (err_clr)
  );

  fis_status_word u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .warm_i    (warm_rst_i),
    .err_set_i (err_set),
    .clr_i     (err_clr),
    .status_o  (status_word_o)
  );

  fis_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .warm_i   (warm_rst_i),
    .wr_i     (wr_cfg),
    .data_i   (wr_data_i),
    .master_i (int_w[BIT_MST]),
    .cfg_o    (cfg_word_o),
    .rdy_o    (ready_o),
    .irq_o    (irq_o)
  );

  assign int_word_o = int_w;

  p_bad_cmd_flags_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_bad && !warm_rst_i) |=> (int_word_o[BIT_MST] && status_word_o[ERR_LSB]));
  p_event_beats_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_int && any_evt && !warm_rst_i) |=> int_word_o[BIT_MST]);
endmodule

// File: tb/flash_irq_status_tb.sv
module flash_irq_status_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        warm;
  logic        wr;
  logic [1:0]  sel;
  logic [15:0] data;
  logic        e_ld, e_prg, e_era, e_rst, e_done;
  logic        f_cmd, f_era, f_prg, f_ld;
  logic [15:0] int_w, stat_w, cfg_w, code;
  logic        irq, rdy, cvalid;

  int vectors = 0;
  int errors  = 0;

  logic [15:0] m_int, m_stat, m_cfg;
  logic        m_rdy;

  always #2 clk = ~clk;

  flash_irq_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm),
    .wr_en_i(wr), .wr_sel_i(sel), .wr_data_i(data),
    .evt_load_i(e_ld), .evt_prog_i(e_prg), .evt_erase_i(e_era),
    .evt_reset_i(e_rst), .evt_done_i(e_done),
    .err_cmd_i(f_cmd), .err_erase_i(f_era), .err_prog_i(f_prg), .err_load_i(f_ld),
    .int_word_o(int_w), .status_word_o(stat_w), .cfg_word_o(cfg_w),
    .irq_o(irq), .ready_o(rdy), .cmd_valid_o(cvalid), .cmd_code_o(code)
  );

  function automatic bit known(input logic [15:0] c);
    bit k = 0;
    foreach (known_list[i]) if (known_list[i] == c) k = 1;
    return k;
  endfunction

  logic [15:0] known_list [17] = '{16'h0000, 16'h0013, 16'h0080, 16'h001A,
    16'h001B, 16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071, 16'h0094,
    16'h0095, 16'h00B0, 16'h0030, 16'h00F0, 16'h00F3, 16'h0065};

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    warm = 0; wr = 0; sel = 2'd3; data = '0;
    e_ld = 0; e_prg = 0; e_era = 0; e_rst = 0; e_done = 0;
    f_cmd = 0; f_era = 0; f_prg = 0; f_ld = 0;
  endtask

  task automatic chk_regs(input string tag);
    chk(tag, "int", int_w, m_int);
    chk(tag, "status", stat_w, m_stat);
    chk(tag, "cfg", cfg_w, m_cfg);
    chk(tag, "ready", {15'd0, rdy}, {15'd0, m_rdy});
    chk(tag, "irq", {15'd0, irq}, {15'd0, m_int[15] ^ !m_cfg[6]});
  endtask

  // inputs are set at a negedge before the call
  task automatic cyc(input string tag);
    bit acc, ok, bad, anyev, clr;
    logic [15:0] ni;
    logic [3:0]  ef;
    #1;
    acc = wr && sel == 2'd2 && !m_int[15];
    ok  = acc && known(data);
    bad = acc && !known(data);
    chk(tag, "cmd_valid", {15'd0, cvalid}, {15'd0, ok});
    if (ok) chk(tag, "cmd_code", code, data);
    chk(tag, "irq", {15'd0, irq}, {15'd0, m_int[15] ^ !m_cfg[6]});
    @(posedge clk);
    if (warm) begin
      m_int = 16'h8010; m_stat = 0; m_cfg = 16'h40C0; m_rdy = 1;
    end else begin
      anyev = e_ld | e_prg | e_era | e_rst | e_done;
      ni = m_int;
      if (wr && sel == 2'd0) ni = ni & data;
      if (anyev || bad) ni[15] = 1;
      if (e_ld)  ni[7] = 1;
      if (e_prg) ni[6] = 1;
      if (e_era) ni[5] = 1;
      if (e_rst) ni[4] = 1;
      ef = anyev ? {f_ld, f_prg, f_era, f_cmd} : 4'b0;
      if (bad) ef[0] = 1;
      clr = wr && sel == 2'd0 && !ni[15];
      if (clr) m_stat = m_stat & ~16'h3C00;
      m_stat = m_stat | {2'b0, ef, 10'b0};
      m_int = ni;
      if (wr && sel == 2'd1) begin m_cfg = data; m_rdy = data[7]; end
    end
    @(negedge clk);
    chk_regs(tag);
    idle();
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
    wr = 1; sel = s; data = d;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    m_int = 16'h8080; m_stat = 0; m_cfg = 16'h40C0; m_rdy = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_regs("R1");
    rst_n = 1;
    @(negedge clk);
    chk_regs("R1");

    // R10: command while master set is dropped
    wr_reg(2'd2, 16'h0080); cyc("R10");
    wr_reg(2'd2, 16'h0055); cyc("R10");
    // R5 / R8: AND clear
    wr_reg(2'd0, 16'hFF7F); cyc("R5");
    wr_reg(2'd0, 16'h0000); cyc("R8");
    // R3 / R4: load with load error
    e_ld = 1; f_ld = 1; cyc("R3");
    // R4: flags without a pulse ignored
    wr_reg(2'd0, 16'h7FFF); cyc("R6");
    f_prg = 1; f_cmd = 1; cyc("R4");
    // R11: known command accepted
    wr_reg(2'd0, 16'h0000); cyc("R5");
    wr_reg(2'd2, 16'h0080); cyc("R11");
    wr_reg(2'd2, 16'h0065); cyc("R11");
    // R12: unknown command
    wr_reg(2'd2, 16'h0055); cyc("R12");
    // R6: master kept, errors kept
    wr_reg(2'd0, 16'hFFFF); cyc("R6");
    wr_reg(2'd0, 16'h8000); cyc("R6");
    // R7: event and clear together
    wr_reg(2'd0, 16'h0000); e_prg = 1; f_prg = 1; cyc("R7");
    wr_reg(2'd0, 16'h0000); cyc("R6");
    // R3: other causes
    e_era = 1; f_era = 1; cyc("R3");
    wr_reg(2'd0, 16'h0000); cyc("R5");
    e_rst = 1; cyc("R3");
    wr_reg(2'd0, 16'h0000); cyc("R5");
    e_done = 1; cyc("R3");
    // R9 / R8: configuration and polarity
    wr_reg(2'd1, 16'h4000); cyc("R9");
    wr_reg(2'd1, 16'h0080); cyc("R8");
    wr_reg(2'd0, 16'h0000); cyc("R8");
    wr_reg(2'd1, 16'h00C0); cyc("R9");
    // R2: warm reset beats a same-cycle event
    e_ld = 1; f_ld = 1; cyc("R4");
    warm = 1; e_prg = 1; wr_reg(2'd1, 16'h0000); cyc("R2");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      warm  = (r[7:0] == 8'd3);
      wr    = r[8];
      sel   = r[10:9];
      data  = r[11] ? 16'h0000 : (r[12] ? 16'h0055 : {r[31:24], r[23:16]});
      if (r[13] && sel == 2'd2) data = known_list[r[20:17] % 17];
      e_ld  = r[14] & r[15];
      e_prg = r[16] & r[15];
      e_era = r[17] & r[21];
      e_rst = r[18] & r[21];
      e_done = r[19] & r[22];
      f_cmd = r[24]; f_era = r[25]; f_prg = r[26]; f_ld = r[27];
      cyc("RND");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule